// File: doc/BRIEF.md
# Dual-Clock Decade Up/Down Counter Stage

This block is one decimal digit of a counter. It keeps a four-bit BCD value. The value steps up on a rising edge of one count clock and steps down on a rising edge of a second, separate count clock. A level-sensitive, active-low load input forces the digit to a parallel value. An active-high clear input forces the digit to zero. Clear takes priority over load, and load takes priority over any count edge.

The stage drives two active-low outputs, carry and borrow. Carry is low while the digit sits at nine and the up clock is in its low phase. Borrow is low while the digit sits at zero and the down clock is in its low phase. Because of this shaping, a carry output can feed the up clock of the next stage and a borrow output can feed its down clock, with no added logic. The next stage then advances on the rising edge of that output.

A fast system clock samples the count clocks, clear, load enable and load data through two-flop synchronizers. The stage detects rising edges of the sampled count clocks. A count edge changes the digit three system clocks after the raw edge. Clear and load take effect after the same three system clocks.

Top module: `bcd_updown_stage`

## Requirements
- R1: While `rst` is high, and after it is released with the count clocks held high, `digit` is 0 and `carry_n` and `borrow_n` are 1.
- R2: While `clear` is high, `digit` becomes 0 within three system clocks. This holds whatever the levels of `load_n` and the count clocks.
- R3: While `load_n` is low and `clear` is low, `digit` takes the value of `load_val` within three system clocks, including values 10 to 15. Count edges have no effect while `load_n` is low.
- R4: A rising edge of `up_clk` while `dn_clk` is high adds one to the digit. The digit goes from 9 to 0, and any loaded value from 10 to 15 also goes to 0.
- R5: A rising edge of `dn_clk` while `up_clk` is high subtracts one from the digit. The digit goes from 0 to 9, and any loaded value from 10 to 15 also goes to 9.
- R6: A rising edge on one count clock while the other count clock is low leaves the digit unchanged.
- R7: `carry_n` is 0 exactly when the digit is 9 and the sampled `up_clk` is low. `borrow_n` is 0 exactly when the digit is 0 and the sampled `dn_clk` is low.
- R8: In a chain where each stage's `carry_n` drives the next stage's `up_clk` and each `borrow_n` drives the next stage's `dn_clk`, the chain counts in decimal. It wraps from 999 to 000 when counting up and from 000 to 999 when counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high system reset |
| clear | input | 1 | Active-high clear to zero, level sensitive |
| load_n | input | 1 | Active-low load enable, level sensitive |
| load_val | input | 4 | Parallel value to load |
| up_clk | input | 1 | Count-up clock, acts on its rising edge |
| dn_clk | input | 1 | Count-down clock, acts on its rising edge |
| digit | output | 4 | Current BCD digit |
| carry_n | output | 1 | Active-low carry, low at 9 during the low phase of the up clock |
| borrow_n | output | 1 | Active-low borrow, low at 0 during the low phase of the down clock |

## Verification
Clear and load can both be active in the same sampled cycle, and load can also coincide with a count edge. The bench holds `load_n` low while it pulses the up clock, and checks that the loaded value is held. It also raises `clear` while `load_n` is low with a non-zero load value, and checks that zero wins. A third collision happens when the inhibiting clock itself rises: releasing the down clock after an inhibited up pulse is a valid down edge. The bench checks that this release steps the digit down.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Control bundle that crosses into the system clock domain together
    typedef struct packed {
        logic   up;
        logic   dn;
        logic   clr;
        logic   ld_n;
        digit_t val;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_IDLE = '{up: 1'b1, dn: 1'b1, clr: 1'b0, ld_n: 1'b1, val: '0};

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_INC,
        OP_DEC
    } digit_op_e;

    function automatic digit_t bcd_inc(input digit_t d);
        return (d >= DIGIT_MAX) ? '0 : digit_t'(d + 1'b1);
    endfunction

    function automatic digit_t bcd_dec(input digit_t d);
        return (d == '0 || d > DIGIT_MAX) ? DIGIT_MAX : digit_t'(d - 1'b1);
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rise[b] = lvl[b] & ~prev_q[b];
    end
endmodule

// File: rtl/digit_core.sv
module digit_core
    import bcd_cnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  digit_op_e op,
    input  digit_t    ld_val,
    output digit_t    digit
);
    digit_t digit_q, digit_d;

    always_comb begin
        unique case (op)
            OP_CLEAR: digit_d = '0;
            OP_LOAD:  digit_d = ld_val;
            OP_INC:   digit_d = bcd_inc(digit_q);
            OP_DEC:   digit_d = bcd_dec(digit_q);
            default:  digit_d = digit_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) digit_q <= '0;
        else     digit_q <= digit_d;
    end

    assign digit = digit_q;
endmodule

// File: rtl/bcd_updown_stage.sv
module bcd_updown_stage
    import bcd_cnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load_n,
    input  logic [3:0]   load_val,
    input  logic         up_clk,
    input  logic         dn_clk,
    output logic [3:0]   digit,
    output logic         carry_n,
    output logic         borrow_n
);
    ctl_t raw_ctl, syn_ctl;
    logic [CTL_W-1:0] syn_vec;
    logic [1:0] edge_vec;

    logic   up_s, dn_s, clr_s, ld_n_s, up_rise, dn_rise;
    digit_t ld_val_s, digit_w;
    digit_op_e op;

    assign raw_ctl = '{up: up_clk, dn: dn_clk, clr: clear, ld_n: load_n, val: load_val};

    ctl_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_ctl),
        .d_out (syn_vec)
    );

    assign syn_ctl  = ctl_t'(syn_vec);
    assign up_s     = syn_ctl.up;
    assign dn_s     = syn_ctl.dn;
    assign clr_s    = syn_ctl.clr;
    assign ld_n_s   = syn_ctl.ld_n;
    assign ld_val_s = syn_ctl.val;

    rise_detect #(
        .W       (2),
        .RST_VAL (2'b11)
    ) edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({up_s, dn_s}),
        .rise (edge_vec)
    );

    assign up_rise = edge_vec[1];
    assign dn_rise = edge_vec[0];

    // Priority: clear, then load, then a qualified up edge, then a qualified down edge
    always_comb begin
        if (clr_s)                 op = OP_CLEAR;
        else if (!ld_n_s)          op = OP_LOAD;
        else if (up_rise && dn_s)  op = OP_INC;
        else if (dn_rise && up_s)  op = OP_DEC;
        else                       op = OP_HOLD;
    end

    digit_core core_i (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ld_val (ld_val_s),
        .digit  (digit_w)
    );

    assign digit    = digit_w;
    assign carry_n  = ~((digit_w == DIGIT_MAX) && !up_s);
    assign borrow_n = ~((digit_w == '0) && !dn_s);
endmodule

// File: rtl/bcd_updown_stage_chk.sv
module bcd_updown_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] digit,
    input logic       carry_n,
    input logic       borrow_n,
    input logic       up_s,
    input logic       dn_s,
    input logic       clr_s,
    input logic       ld_n_s,
    input logic [3:0] ld_val_s,
    input logic       up_rise,
    input logic       dn_rise
);
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_s |=> (digit == 4'd0));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_s && !ld_n_s) |=> (digit == $past(ld_val_s)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_s && ld_n_s && !(up_rise && dn_s) && !(dn_rise && up_s)) |=> $stable(digit));

    // R4
    bcd_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_n_s && digit <= 4'd9) |=> (digit <= 4'd9));

    // R7
    carry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (digit != 4'd9) |-> carry_n);

    // R7
    borrow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (digit != 4'd0) |-> borrow_n);
endmodule

bind bcd_updown_stage bcd_updown_stage_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .digit    (digit),
    .carry_n  (carry_n),
    .borrow_n (borrow_n),
    .up_s     (up_s),
    .dn_s     (dn_s),
    .clr_s    (clr_s),
    .ld_n_s   (ld_n_s),
    .ld_val_s (ld_val_s),
    .up_rise  (up_rise),
    .dn_rise  (dn_rise)
);

// File: tb/bcd_updown_stage_tb_top.sv
module bcd_updown_stage_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, clear, load_n, up0, dn0;
    logic [3:0] lv0, lv1, lv2;
    logic [3:0] d0, d1, d2;
    logic       c0, b0, c1, b1, c2, b2;

    int  n_chk = 0;
    int  n_fail = 0;
    int  ref_val;
    bit  done = 0;

    bcd_updown_stage dut_i (.clk(clk), .rst(rst), .clear(clear), .load_n(load_n),
        .load_val(lv0), .up_clk(up0), .dn_clk(dn0), .digit(d0), .carry_n(c0), .borrow_n(b0));
    bcd_updown_stage st1_i (.clk(clk), .rst(rst), .clear(clear), .load_n(load_n),
        .load_val(lv1), .up_clk(c0), .dn_clk(b0), .digit(d1), .carry_n(c1), .borrow_n(b1));
    bcd_updown_stage st2_i (.clk(clk), .rst(rst), .clear(clear), .load_n(load_n),
        .load_val(lv2), .up_clk(c1), .dn_clk(b1), .digit(d2), .carry_n(c2), .borrow_n(b2));

    function automatic int total();
        return int'(d2) * 100 + int'(d1) * 10 + int'(d0);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        up0 = 1'b0; idle(12);
        up0 = 1'b1; idle(12);
    endtask

    task automatic pulse_dn();
        dn0 = 1'b0; idle(12);
        dn0 = 1'b1; idle(12);
    endtask

    task automatic load_dec(input int v);
        lv2 = 4'(v / 100); lv1 = 4'((v / 10) % 10); lv0 = 4'(v % 10);
        load_n = 1'b0; idle(5);
        load_n = 1'b1; idle(5);
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(4);
        chk("R1 digit in reset", total(), 0);
        rst = 1'b0; idle(4);
        chk("R1 digit after reset", total(), 0);
        chk("R1 carry_n", int'(c0), 1);
        chk("R1 borrow_n", int'(b0), 1);
    endtask

    task automatic t_load();
        lv2 = 4'd2; lv1 = 4'd9; lv0 = 4'd5;
        load_n = 1'b0; idle(5);
        chk("R3 load value", total(), 295);
        pulse_up();
        chk("R3 load beats up edge", total(), 295);
        load_n = 1'b1; idle(5);
        chk("R3 value kept after release", total(), 295);
    endtask

    task automatic t_clear();
        lv2 = 4'd7; lv1 = 4'd7; lv0 = 4'd7;
        load_n = 1'b0; clear = 1'b1; idle(5);
        chk("R2 clear beats load", total(), 0);
        clear = 1'b0; load_n = 1'b1; idle(5);
        chk("R2 zero after release", total(), 0);
    endtask

    task automatic t_carry_borrow();
        load_dec(9);
        up0 = 1'b0; idle(4);
        chk("R7 carry low at 9 in up low phase", int'(c0), 0);
        up0 = 1'b1; idle(12);
        chk("R7 carry high again", int'(c0), 1);
        chk("R4 9 wraps with carry", total(), 10);
        dn0 = 1'b0; idle(4);
        chk("R7 borrow low at 0 in down low phase", int'(b0), 0);
        dn0 = 1'b1; idle(12);
        chk("R5 0 wraps with borrow", total(), 9);
        chk("R7 borrow high again", int'(b0), 1);
    endtask

    task automatic t_wrap_up();
        load_dec(995);
        ref_val = 995;
        for (int i = 0; i < 8; i++) begin
            pulse_up();
            ref_val = (ref_val + 1) % 1000;
            chk("R8 cascade up count", total(), ref_val);
        end
    endtask

    task automatic t_wrap_dn();
        load_dec(3);
        ref_val = 3;
        for (int i = 0; i < 6; i++) begin
            pulse_dn();
            ref_val = (ref_val + 999) % 1000;
            chk("R8 cascade down count", total(), ref_val);
        end
    endtask

    task automatic t_inhibit();
        load_dec(5);
        dn0 = 1'b0; idle(4);
        pulse_up();
        chk("R6 up edge ignored while down low", total(), 5);
        dn0 = 1'b1; idle(12);
        chk("R5 down release counts down", total(), 4);
    endtask

    task automatic t_invalid();
        lv2 = 4'd0; lv1 = 4'd0; lv0 = 4'd12;
        load_n = 1'b0; idle(5); load_n = 1'b1; idle(5);
        chk("R3 loads 12 as is", int'(d0), 12);
        pulse_up();
        chk("R4 12 counts up to 0", int'(d0), 0);
        chk("R4 no carry from 12", int'(d1), 0);
        lv0 = 4'd13;
        load_n = 1'b0; idle(5); load_n = 1'b1; idle(5);
        pulse_dn();
        chk("R5 13 counts down to 9", int'(d0), 9);
        chk("R5 no borrow from 13", int'(d1), 0);
    endtask

    initial begin
        rst = 1'b1; clear = 1'b0; load_n = 1'b1; up0 = 1'b1; dn0 = 1'b1;
        lv0 = '0; lv1 = '0; lv2 = '0;
        t_reset();
        t_load();
        t_clear();
        t_carry_borrow();
        t_wrap_up();
        t_wrap_dn();
        t_inhibit();
        t_invalid();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule